// File: doc/BRIEF.md
# Loop Lock Window Detector

This block decides whether a clock-recovery loop has settled. It runs on the loop's own oscillator clock. The reference input and the divided-down feedback input each pass through a short synchroniser, and the block detects their rising edges. Around every reference edge it opens an acceptance window that is measured in ticks of a half-rate timebase. A reference period passes when one feedback edge lands inside the window, either shortly before the reference edge or shortly after it. A period fails when the feedback edge is outside the window or missing. Passing periods add to a run length. Any failing period clears the run.

The lock pin is modelled as an open-drain sink. When the block asserts the sink, the pin is pulled low and reads "not locked". When it releases the sink, an external pull-up makes the pin read "locked". The sink is released only after a long unbroken run of passing periods. One failing period pulls the pin low again. All pins are plain control and status levels, so there is no stream interface and no back-pressure. Detection is active only while the PLL-mode enable is high.

Top module: `lock_window_detector`

## Requirements
- R1: While reset is asserted (active low) and after it is released, `lock_sink` is 1 (pin pulled low) until a full run of passing periods has been counted.
- R2: `ref_in` and `var_in` each pass through a two-flop synchroniser and then a previous-value flop. A rising edge on an input is acted on in the third clock after the input rises. Each rising edge produces exactly one single-cycle event.
- R3: The half-rate timebase advances once every second oscillator clock, counting from reset. A feedback edge that arrives at most 6 timebase ticks before a reference edge makes that reference period pass. A feedback edge that arrives 8 or more ticks before the reference edge does not.
- R4: If no feedback edge preceded the reference edge, a window stays open for the next 6 timebase ticks. A feedback edge inside that window makes the period pass. A feedback edge that arrives after the window closes does not.
- R5: A feedback edge and a reference edge that reach the detector in the same clock make that period pass.
- R6: A period whose window closes with no feedback edge fails. A failing period clears the run to zero, and `lock_sink` is 1 from the next clock.
- R7: `lock_sink` drops to 0 in the clock after the 512th consecutive passing period (LOCK_RUN), and not earlier.
- R8: The run saturates at 512. Further passing periods keep `lock_sink` at 0.
- R9: While `pll_mode` is 0, no windows are evaluated, the run is cleared, and `lock_sink` is 1. When `pll_mode` returns to 1, counting restarts from zero.
- R10: A second reference edge that arrives while a window is still open fails the period, and that second edge is not evaluated.
- R11: A feedback edge credits at most one reference period. Once it has made a period pass, a later reference edge cannot use it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk_osc |
| var_in | input | 1 | Divided-down feedback signal, asynchronous to clk_osc |
| pll_mode | input | 1 | 1 enables lock detection, 0 clears it |
| lock_sink | output | 1 | Open-drain pull-down enable: 1 pulls the lock pin low, 0 releases it to the pull-up (locked) |

## Verification
Three events can land in the same clock: a synchronised reference edge, a synchronised feedback edge, and the expiry of an open window. The bench drives feedback pulses at offsets of -16, -8, 0, +8 and +16 clocks from the reference pulse, so some edges coincide exactly and others fall on either side of the window limits. It also sends double reference pulses that overlap an open window or an edge that was already used. A behavioural model predicts the lock pin on every clock, and the bench compares it against the design. Milestone checks confirm that the pin is still low after 511 passing periods and released after 512.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  // Outcome of evaluating one reference period.
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_HIT  = 2'd1,
    VERD_MISS = 2'd2
  } verdict_t;
endpackage

// File: rtl/lwd_edge_sync.sv
module lwd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;

  // A synchronised edge is a single-cycle event.
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lwd_window.sv
module lwd_window
  import lwd_pkg::*;
#(
  parameter int HALF_WIN = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     ref_rise,
  input  logic     var_rise,
  output verdict_t verdict
);
  localparam int AGE_W = $clog2(HALF_WIN + 2);
  localparam int PC_W  = $clog2(HALF_WIN + 1);
  localparam logic [AGE_W-1:0] STALE   = AGE_W'(HALF_WIN + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(HALF_WIN);
  localparam logic [PC_W-1:0]  PC_LAST = PC_W'(HALF_WIN - 1);

  logic             phase;      // half-rate timebase: tick when high
  logic [AGE_W-1:0] var_age, var_age_nx;
  logic             armed, armed_nx;
  logic [PC_W-1:0]  post_cnt, post_cnt_nx;
  logic             consume;
  logic             tick;

  assign tick = phase;

  always_comb begin
    verdict     = VERD_NONE;
    armed_nx    = armed;
    post_cnt_nx = post_cnt;
    consume     = 1'b0;
    if (enable) begin
      if (ref_rise) begin
        if (armed) begin
          verdict  = VERD_MISS;          // overlapping reference edge
          armed_nx = 1'b0;
        end else if (var_rise || (var_age <= AGE_LIM)) begin
          verdict = VERD_HIT;            // early or coincident feedback
          consume = 1'b1;
        end else begin
          armed_nx    = 1'b1;            // open the trailing half
          post_cnt_nx = '0;
        end
      end else if (armed) begin
        if (var_rise) begin
          verdict  = VERD_HIT;
          consume  = 1'b1;
          armed_nx = 1'b0;
        end else if (tick) begin
          if (post_cnt == PC_LAST) begin
            verdict  = VERD_MISS;
            armed_nx = 1'b0;
          end else begin
            post_cnt_nx = post_cnt + 1'b1;
          end
        end
      end
    end else begin
      armed_nx = 1'b0;
    end

    if (!enable || consume)            var_age_nx = STALE;
    else if (var_rise)                 var_age_nx = '0;
    else if (tick && var_age < STALE)  var_age_nx = var_age + 1'b1;
    else                               var_age_nx = var_age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      var_age  <= STALE;
      armed    <= 1'b0;
      post_cnt <= '0;
    end else begin
      phase    <= ~phase;
      var_age  <= var_age_nx;
      armed    <= armed_nx;
      post_cnt <= post_cnt_nx;
    end
  end

  // The trailing window never runs past its width.
  assert_window_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (post_cnt <= PC_LAST));
  // A verdict only comes from a reference edge or an open window.
  assert_verdict_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != VERD_NONE) |-> (ref_rise || armed));
  // With detection disabled, no window survives.
  assert_disable_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !armed);
endmodule

// File: rtl/lwd_run_counter.sv
module lwd_run_counter
  import lwd_pkg::*;
#(
  parameter int LOCK_RUN = 512
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  verdict_t verdict,
  output logic     locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!enable) begin
      run_cnt <= '0;
    end else begin
      unique case (verdict)
        VERD_MISS: run_cnt <= '0;
        VERD_HIT:  if (run_cnt != RUN_TOP) run_cnt <= run_cnt + 1'b1;
        default:   run_cnt <= run_cnt;
      endcase
    end
  end

  assign locked = (run_cnt == RUN_TOP);

  // The run length saturates at the lock threshold.
  assert_run_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_TOP);
endmodule

// File: rtl/lock_window_detector.sv
module lock_window_detector
  import lwd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_WIN    = 6,
  parameter int LOCK_RUN    = 512
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic ref_in,
  input  logic var_in,
  input  logic pll_mode,
  output logic lock_sink
);
  logic     ref_rise;
  logic     var_rise;
  verdict_t verdict;
  logic     locked;

  lwd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk_osc), .rst_n(rst_n), .async_in(ref_in), .rise(ref_rise)
  );

  lwd_edge_sync #(.STAGES(SYNC_STAGES)) u_var_sync (
    .clk(clk_osc), .rst_n(rst_n), .async_in(var_in), .rise(var_rise)
  );

  lwd_window #(.HALF_WIN(HALF_WIN)) u_window (
    .clk(clk_osc), .rst_n(rst_n), .enable(pll_mode),
    .ref_rise(ref_rise), .var_rise(var_rise), .verdict(verdict)
  );

  lwd_run_counter #(.LOCK_RUN(LOCK_RUN)) u_run (
    .clk(clk_osc), .rst_n(rst_n), .enable(pll_mode),
    .verdict(verdict), .locked(locked)
  );

  // Open-drain: pull the pin low unless the run is complete.
  assign lock_sink = ~locked;

  // A failing period pulls the pin low on the next clock.
  assert_miss_pulls_low_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (verdict == VERD_MISS) |=> lock_sink);
  // The pin is released only right after a passing period.
  assert_release_after_hit_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(lock_sink) |-> $past(verdict == VERD_HIT));
  // Leaving PLL mode holds the pin low.
  assert_mode_off_low_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !pll_mode |=> lock_sink);
endmodule

// File: tb/lock_window_detector_tb.sv
module lock_window_detector_tb;
  localparam int HW     = 6;
  localparam int LR     = 512;
  localparam int STALE  = HW + 1;
  localparam int PERIOD = 40;
  localparam int REF_AT = 20;

  logic clk_osc = 1'b0;
  logic rst_n   = 1'b0;
  logic ref_in  = 1'b0;
  logic var_in  = 1'b0;
  logic pll_mode = 1'b0;
  logic lock_sink;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  always #2 clk_osc = ~clk_osc;   // 250 MHz

  lock_window_detector u_dut (
    .clk_osc(clk_osc), .rst_n(rst_n), .ref_in(ref_in), .var_in(var_in),
    .pll_mode(pll_mode), .lock_sink(lock_sink)
  );

  // Behavioural reference model, one step per clock.
  int rq[3], vq[3];
  int m_ph, m_age, m_armed, m_pcnt, m_run;

  always @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      foreach (rq[i]) begin rq[i] = 0; vq[i] = 0; end
      m_ph = 0; m_age = STALE; m_armed = 0; m_pcnt = 0; m_run = 0;
    end else begin
      int rr, vr, tk, hit, miss, cons, n_armed, n_pcnt;
      rr = rq[1] && !rq[2];
      vr = vq[1] && !vq[2];
      tk = m_ph;
      hit = 0; miss = 0; cons = 0;
      n_armed = m_armed; n_pcnt = m_pcnt;
      if (pll_mode) begin
        if (rr) begin
          if (m_armed) begin miss = 1; n_armed = 0; end
          else if (vr || m_age <= HW) begin hit = 1; cons = 1; end
          else begin n_armed = 1; n_pcnt = 0; end
        end else if (m_armed) begin
          if (vr) begin hit = 1; cons = 1; n_armed = 0; end
          else if (tk) begin
            if (m_pcnt == HW - 1) begin miss = 1; n_armed = 0; end
            else n_pcnt = m_pcnt + 1;
          end
        end
      end else n_armed = 0;
      if (!pll_mode || cons)           m_age = STALE;
      else if (vr)                     m_age = 0;
      else if (tk && m_age < STALE)    m_age = m_age + 1;
      if (!pll_mode || miss)           m_run = 0;
      else if (hit && m_run < LR)      m_run = m_run + 1;
      m_armed = n_armed; m_pcnt = n_pcnt;
      rq[2] = rq[1]; rq[1] = rq[0]; rq[0] = ref_in;
      vq[2] = vq[1]; vq[1] = vq[0]; vq[0] = var_in;
      m_ph = !m_ph;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lock_sink=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the edge.
  always @(negedge clk_osc) begin
    if (rst_n && !done) chk(cur_tag, lock_sink, (m_run == LR) ? 1'b0 : 1'b1);
  end

  // One reference period: reference pulse at REF_AT, optional second
  // reference pulse at ref2_at, feedback pulse at var_at (negative = none).
  task automatic period(input int var_at, input int ref2_at);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk_osc);
      ref_in = (c >= REF_AT && c < REF_AT + 4) ||
               (ref2_at >= 0 && c >= ref2_at && c < ref2_at + 3);
      var_in = (var_at >= 0 && c >= var_at && c < var_at + 3);
    end
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) period(REF_AT + ((i % 3) - 1) * 8, -1);
  endtask

  task automatic settle_check(input string tag, input logic exp);
    repeat (4) @(negedge clk_osc);
    chk(tag, lock_sink, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk_osc);
    chk("R1", lock_sink, 1'b1);              // held in reset
    rst_n = 1'b1;
    @(negedge clk_osc);
    chk("R1", lock_sink, 1'b1);
    pll_mode = 1'b1;

    cur_tag = "R7";
    hits(LR - 1);
    settle_check("R7", 1'b1);                // 511 passes: still low
    period(REF_AT, -1);
    settle_check("R7", 1'b0);                // 512th pass releases

    cur_tag = "R8";
    hits(20);
    settle_check("R8", 1'b0);
    period(REF_AT, -1);
    settle_check("R5", 1'b0);                // coincident edges pass
    period(REF_AT - 8, -1);
    settle_check("R3", 1'b0);                // 4 ticks early passes
    period(REF_AT + 8, -1);
    settle_check("R4", 1'b0);                // 4 ticks late passes

    cur_tag = "R4";
    period(REF_AT + 16, -1);
    settle_check("R4", 1'b1);                // 8 ticks late fails

    cur_tag = "R6";
    hits(300);
    period(-1, -1);                          // no feedback edge
    hits(LR - 1);
    settle_check("R6", 1'b1);                // run restarted
    period(REF_AT, -1);
    settle_check("R6", 1'b0);

    cur_tag = "R9";
    pll_mode = 1'b0;
    period(REF_AT, -1);
    settle_check("R9", 1'b1);
    pll_mode = 1'b1;
    hits(LR - 1);
    settle_check("R9", 1'b1);
    period(REF_AT, -1);
    settle_check("R9", 1'b0);

    cur_tag = "R10";
    period(34, 28);                          // second ref inside open window
    settle_check("R10", 1'b1);
    hits(LR);
    settle_check("R10", 1'b0);

    cur_tag = "R11";
    period(16, 28);                          // one feedback edge, two refs
    settle_check("R11", 1'b1);
    hits(LR);
    settle_check("R11", 1'b0);

    cur_tag = "R3";
    period(REF_AT - 16, -1);                 // 8 ticks early fails
    settle_check("R3", 1'b1);

    cur_tag = "R2";
    period(REF_AT, -1);
    settle_check("R2", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_osc);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule